// File: doc/BRIEF.md
# Line Sensor Acquisition Controller

This block sits on the host side of one or two linear photodiode sensors that carry their own charge amplifiers and shift registers. It derives the sensor clock from the system clock and drives the sensor reset line. The reset high time is the exposure and is programmable. The block also guarantees the sensor's reset timing rules. Every reset edge lands on a rising sensor clock edge. Reset never rises while a readout is still running. A frame is never shorter than the sensor's minimum cycle of 16.5 + 4N clocks, rounded up to 17 + 4N.

During readout each rising edge of the sensor trigger latches one word from the external ADC. The word leaves on a valid/ready stream with a 1-based channel number and first and last markers. Three arrangements are supported:
- a single sensor;
- two sensors chained on one video line, numbered as one long line;
- two sensors read side by side, whose triggers are merged by OR into one strobe.

A sample counter checks each readout against the end-of-scan pulses and raises a sticky error on any mismatch.

Top module: `linescan_acq`

## Requirements
- R1: `sensClk` toggles every `cfgHalf` system clocks, so its period is 2·`cfgHalf` system clocks. A `cfgHalf` of 0 acts as 1.
- R2: `sensRst` changes only on the system clock edge where `sensClk` goes from 0 to 1.
- R3: `sensRst` stays high for exactly `cfgInteg` sensor clock periods (0 acts as 1).
- R4: While readout ends in time, successive reset rises are max(`cfgPeriod`, 17 + 4N) sensor clock periods apart. N is CH for `cfgMode` 0 (single), 2 (parallel) and 3 (treated as single), and 2·CH for `cfgMode` 1 (cascade). At each rise `stretched` becomes 1 if `cfgPeriod` < 17 + 4N and 0 otherwise.
- R5: Readout runs from the reset fall until the final end-of-scan rising edge, and no reset rise occurs during readout. Once readout ends, the next rise waits at most one sensor clock beyond the period limit.
- R6: During readout each capture-strobe rising edge presents `adcData` on `outData` with `outChan` = 1..N in order. `outFirst` is set only on channel 1 and `outLast` only on channel N.
- R7: In single mode `trigB` is ignored and the strobe is `trigA`. In cascade and parallel modes the strobe is `trigA | trigB`, so overlapping pulses on both make a single capture.
- R8: In cascade mode channels run 1..2·CH across both sensors and the final end-of-scan is `eosB`. An `eosA` rising edge with a count other than CH sets `countErr`.
- R9: `outValid` holds, with `outData` unchanged, until `outReady` is seen. A capture while `outValid` is high and `outReady` is low sets the sticky `overrun` and replaces the held word.
- R10: The sticky `countErr` is set by a strobe after N samples (that strobe is dropped) or by a final end-of-scan with a count other than N. In single and parallel modes the final end-of-scan is `eosA`.
- R11: With `enable` low no reset rise occurs and `sensRst` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new frames to start |
| cfgMode | input | 2 | 0 single, 1 cascade, 2 parallel, 3 single |
| cfgHalf | input | DIV_W | Sensor clock half period in system clocks |
| cfgInteg | input | CNT_W | Reset high time in sensor clocks |
| cfgPeriod | input | CNT_W | Requested frame period in sensor clocks |
| sensClk | output | 1 | Sensor clock |
| sensRst | output | 1 | Sensor reset / exposure gate |
| trigA | input | 1 | Trigger from sensor A |
| trigB | input | 1 | Trigger from sensor B |
| eosA | input | 1 | End of scan from sensor A, active high |
| eosB | input | 1 | End of scan from sensor B, active high |
| adcData | input | 2·SAMPLE_W | ADC words; lane 0 sensor A, lane 1 sensor B |
| outValid | output | 1 | Output sample valid |
| outReady | input | 1 | Downstream ready |
| outData | output | 2·SAMPLE_W | Captured ADC word |
| outChan | output | CHAN_W | 1-based channel number |
| outFirst | output | 1 | Marks channel 1 |
| outLast | output | 1 | Marks channel N |
| stretched | output | 1 | Current frame was lengthened to the minimum |
| overrun | output | 1 | Sticky: sample replaced before being taken |
| countErr | output | 1 | Sticky: sample count disagrees with end of scan |

## Verification
The bench holds the end-of-scan back for well over a frame period. A controller that checked only the period counter would raise reset in the middle of the video, and one that missed the busy release would stall forever. Short requested periods test the 17 + 4N floor in each mode, where a wrong N or a dropped round-up shows up as a wrong rise-to-rise distance. Cascade tests include both a correct and an early `eosA`, and parallel tests include staggered overlapping triggers that must give one capture, not two. Backpressure, surplus strobes and a short readout test the sticky flags and confirm that the held word is neither lost nor duplicated.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_CASCADE  = 2'd1,
    MODE_PARALLEL = 2'd2,
    MODE_SPARE    = 2'd3
  } acqMode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } frameSt_t;

  // strobes from frame control to the capture datapath
  typedef struct packed {
    logic readStart;   // one-cycle pulse after reset falls
    logic readActive;  // readout window open
  } ctrlStrobe_t;

  // channels read out on the shared line for a given mode
  function automatic int chanTotal(input logic [1:0] mode, input int perSensor);
    return (mode == MODE_CASCADE) ? 2 * perSensor : perSensor;
  endfunction

endpackage

// File: rtl/lsa_frame_ctrl.sv
module lsa_frame_ctrl
  import lsa_pkg::*;
#(
  parameter int CH    = 16,
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        cfgMode,
  input  logic [DIV_W-1:0]  cfgHalf,
  input  logic [CNT_W-1:0]  cfgInteg,
  input  logic [CNT_W-1:0]  cfgPeriod,
  input  logic              readoutDone,
  output logic              sensClk,
  output logic              sensRst,
  output logic              stretched,
  output ctrlStrobe_t       strobe
);

  localparam int MIN_BASE = 17;   // 16.5 clocks rounded up
  localparam int PER_CHAN = 4;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfEff;
  logic             sensClkQ;
  logic             sensRstQ;
  logic             busyQ;
  logic             startQ;
  logic             stretchQ;
  frameSt_t         st;
  logic [CNT_W-1:0] frameCnt;
  logic [CNT_W-1:0] integEff;
  logic [CNT_W-1:0] minPer;
  logic [CNT_W-1:0] perEff;
  logic [CNT_W:0]   cntNext;
  logic             divWrap;
  logic             scRise;
  logic             canRise;
  logic             riseNow;
  logic             fallNow;

  assign halfEff  = (cfgHalf == '0) ? DIV_W'(1) : cfgHalf;
  assign divWrap  = (divCnt >= halfEff - DIV_W'(1));
  assign scRise   = divWrap && !sensClkQ;

  assign minPer   = CNT_W'(MIN_BASE + PER_CHAN * chanTotal(cfgMode, CH));
  assign integEff = (cfgInteg == '0) ? CNT_W'(1) : cfgInteg;
  assign perEff   = (cfgPeriod > minPer) ? cfgPeriod : minPer;
  assign cntNext  = {1'b0, frameCnt} + (CNT_W+1)'(1);

  assign canRise  = enable && !busyQ &&
                    ((st == ST_IDLE) ||
                     ((st == ST_LOW) && (cntNext >= {1'b0, perEff})));
  assign riseNow  = scRise && canRise;
  assign fallNow  = scRise && (st == ST_HIGH) && (cntNext >= {1'b0, integEff});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      sensClkQ <= 1'b0;
      sensRstQ <= 1'b0;
      busyQ    <= 1'b0;
      startQ   <= 1'b0;
      stretchQ <= 1'b0;
      st       <= ST_IDLE;
      frameCnt <= '0;
    end else begin
      if (divWrap) begin
        divCnt   <= '0;
        sensClkQ <= ~sensClkQ;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end

      startQ <= fallNow;

      if (riseNow) begin
        st       <= ST_HIGH;
        sensRstQ <= 1'b1;
        frameCnt <= '0;
        stretchQ <= (cfgPeriod < minPer);
      end else if (fallNow) begin
        st       <= ST_LOW;
        sensRstQ <= 1'b0;
        frameCnt <= cntNext[CNT_W-1:0];
      end else if (scRise && (st != ST_IDLE) && (frameCnt != '1)) begin
        frameCnt <= cntNext[CNT_W-1:0];
      end

      if (fallNow)          busyQ <= 1'b1;
      else if (readoutDone) busyQ <= 1'b0;
    end
  end

  assign sensClk           = sensClkQ;
  assign sensRst           = sensRstQ;
  assign stretched         = stretchQ;
  assign strobe.readStart  = startQ;
  assign strobe.readActive = busyQ;

  AST_RST_EDGE_ON_CLK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sensRstQ) |-> $rose(sensClkQ)); // R2

  AST_NO_RISE_IN_READOUT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sensRstQ) |-> !$past(busyQ)); // R5

  AST_READOUT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sensRstQ) |-> busyQ); // R5

  AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sensRstQ) |-> $past(enable)); // R11

endmodule

// File: rtl/lsa_capture.sv
module lsa_capture
  import lsa_pkg::*;
#(
  parameter int CH       = 16,
  parameter int SAMPLE_W = 12,
  parameter int CHAN_W   = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            cfgMode,
  input  ctrlStrobe_t           strobe,
  input  logic                  trigA,
  input  logic                  trigB,
  input  logic                  eosA,
  input  logic                  eosB,
  input  logic [2*SAMPLE_W-1:0] adcData,
  input  logic                  outReady,
  output logic                  outValid,
  output logic [2*SAMPLE_W-1:0] outData,
  output logic [CHAN_W-1:0]     outChan,
  output logic                  outFirst,
  output logic                  outLast,
  output logic                  overrun,
  output logic                  countErr,
  output logic                  readoutDone
);

  logic [CHAN_W-1:0]     nTot;
  logic [CHAN_W-1:0]     sampCnt;
  logic [CHAN_W-1:0]     sampNext;
  logic                  isCascade;
  logic                  isParallel;
  logic                  trigSel;
  logic                  trigQ;
  logic                  eosAQ;
  logic                  eosBQ;
  logic                  eosARise;
  logic                  eosBRise;
  logic                  capHit;
  logic                  capOk;
  logic                  finalEos;
  logic                  midEos;
  logic                  validQ;
  logic [2*SAMPLE_W-1:0] dataQ;
  logic [CHAN_W-1:0]     chanQ;
  logic                  firstQ;
  logic                  lastQ;
  logic                  overrunQ;
  logic                  countErrQ;

  assign nTot       = CHAN_W'(chanTotal(cfgMode, CH));
  assign isCascade  = (cfgMode == MODE_CASCADE);
  assign isParallel = (cfgMode == MODE_PARALLEL);

  // single sensor listens to A only; two-sensor arrangements merge by OR
  assign trigSel  = (isCascade || isParallel) ? (trigA | trigB) : trigA;
  assign eosARise = eosA && !eosAQ;
  assign eosBRise = eosB && !eosBQ;

  assign capHit   = strobe.readActive && trigSel && !trigQ;
  assign capOk    = capHit && (sampCnt < nTot);
  assign sampNext = sampCnt + CHAN_W'(1);
  assign finalEos = strobe.readActive && (isCascade ? eosBRise : eosARise);
  assign midEos   = strobe.readActive && isCascade && eosARise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigQ     <= 1'b0;
      eosAQ     <= 1'b0;
      eosBQ     <= 1'b0;
      sampCnt   <= '0;
      validQ    <= 1'b0;
      dataQ     <= '0;
      chanQ     <= '0;
      firstQ    <= 1'b0;
      lastQ     <= 1'b0;
      overrunQ  <= 1'b0;
      countErrQ <= 1'b0;
    end else begin
      trigQ <= trigSel;
      eosAQ <= eosA;
      eosBQ <= eosB;

      if (strobe.readStart) sampCnt <= '0;
      else if (capOk)       sampCnt <= sampNext;

      if (capOk) begin
        validQ <= 1'b1;
        dataQ  <= adcData;
        chanQ  <= sampNext;
        firstQ <= (sampCnt == '0);
        lastQ  <= (sampNext == nTot);
      end else if (outReady) begin
        validQ <= 1'b0;
      end

      if (capOk && validQ && !outReady) overrunQ <= 1'b1;

      if ((capHit && !capOk) ||
          (finalEos && (sampCnt != nTot)) ||
          (midEos && (sampCnt != CHAN_W'(CH))))
        countErrQ <= 1'b1;
    end
  end

  assign outValid    = validQ;
  assign outData     = dataQ;
  assign outChan     = chanQ;
  assign outFirst    = firstQ;
  assign outLast     = lastQ;
  assign overrun     = overrunQ;
  assign countErr    = countErrQ;
  assign readoutDone = finalEos;

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> (chanQ >= CHAN_W'(1)) && (chanQ <= nTot)); // R6

  AST_FIRST_IS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && firstQ) |-> (chanQ == CHAN_W'(1))); // R6

  AST_LAST_IS_N: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && lastQ) |-> (chanQ == nTot)); // R6

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !outReady) |=> validQ); // R9

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrunQ |=> overrunQ); // R9

  AST_COUNT_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    countErrQ |=> countErrQ); // R10

endmodule

// File: rtl/linescan_acq.sv
module linescan_acq
  import lsa_pkg::*;
#(
  parameter int CH       = 16,
  parameter int SAMPLE_W = 12,
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 16,
  localparam int CHAN_W  = $clog2(2 * CH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic [1:0]            cfgMode,
  input  logic [DIV_W-1:0]      cfgHalf,
  input  logic [CNT_W-1:0]      cfgInteg,
  input  logic [CNT_W-1:0]      cfgPeriod,
  output logic                  sensClk,
  output logic                  sensRst,
  input  logic                  trigA,
  input  logic                  trigB,
  input  logic                  eosA,
  input  logic                  eosB,
  input  logic [2*SAMPLE_W-1:0] adcData,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [2*SAMPLE_W-1:0] outData,
  output logic [CHAN_W-1:0]     outChan,
  output logic                  outFirst,
  output logic                  outLast,
  output logic                  stretched,
  output logic                  overrun,
  output logic                  countErr
);

  ctrlStrobe_t strobe;
  logic        readoutDone;

  lsa_frame_ctrl #(
    .CH(CH), .DIV_W(DIV_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgMode(cfgMode),
    .cfgHalf(cfgHalf), .cfgInteg(cfgInteg), .cfgPeriod(cfgPeriod),
    .readoutDone(readoutDone), .sensClk(sensClk), .sensRst(sensRst),
    .stretched(stretched), .strobe(strobe)
  );

  lsa_capture #(
    .CH(CH), .SAMPLE_W(SAMPLE_W), .CHAN_W(CHAN_W)
  ) u_cap (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .strobe(strobe),
    .trigA(trigA), .trigB(trigB), .eosA(eosA), .eosB(eosB),
    .adcData(adcData), .outReady(outReady), .outValid(outValid),
    .outData(outData), .outChan(outChan), .outFirst(outFirst),
    .outLast(outLast), .overrun(overrun), .countErr(countErr),
    .readoutDone(readoutDone)
  );

endmodule

// File: tb/linescan_acq_bench.sv
module linescan_acq_bench;
  localparam int CH  = 4;
  localparam int SW  = 12;
  localparam int DW  = 8;
  localparam int CW  = 16;
  localparam int CHW = $clog2(2 * CH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] cfgMode = 2'd0;
  logic [DW-1:0] cfgHalf = 8'd2;
  logic [CW-1:0] cfgInteg = 16'd1;
  logic [CW-1:0] cfgPeriod = 16'd1;
  logic trigA = 1'b0, trigB = 1'b0, eosA = 1'b0, eosB = 1'b0;
  logic [2*SW-1:0] adcData = '0;
  logic outReady = 1'b1;
  logic sensClk, sensRst, outValid, outFirst, outLast, stretched, overrun, countErr;
  logic [2*SW-1:0] outData;
  logic [CHW-1:0] outChan;

  linescan_acq #(.CH(CH), .SAMPLE_W(SW), .DIV_W(DW), .CNT_W(CW)) u_linescan_acq (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgMode(cfgMode),
    .cfgHalf(cfgHalf), .cfgInteg(cfgInteg), .cfgPeriod(cfgPeriod),
    .sensClk(sensClk), .sensRst(sensRst), .trigA(trigA), .trigB(trigB),
    .eosA(eosA), .eosB(eosB), .adcData(adcData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outChan(outChan),
    .outFirst(outFirst), .outLast(outLast), .stretched(stretched),
    .overrun(overrun), .countErr(countErr)
  );

  always #2 clk = ~clk;   // 250 MHz

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  always @(posedge clk) cyc++;

  // port monitor, sampled away from the active edge
  logic pClk = 1'b0, pRst = 1'b0;
  int riseCnt = 0, fallCnt = 0, riseT = 0, fallT = 0;
  int clkRiseT = 0, clkPer = 0, r2Bad = 0, capN = 0;
  logic [2*SW-1:0] capD [32];
  logic [CHW-1:0]  capC [32];
  logic            capF [32];
  logic            capL [32];

  always @(negedge clk) begin
    if (sensClk && !pClk) begin
      clkPer   = cyc - clkRiseT;
      clkRiseT = cyc;
    end
    if (rstN) begin
      if ((sensRst != pRst) && !(sensClk && !pClk)) r2Bad++;
      if (sensRst && !pRst) begin riseCnt++; riseT = cyc; end
      if (!sensRst && pRst) begin fallCnt++; fallT = cyc; end
      if (outValid && outReady && capN < 32) begin
        capD[capN] = outData; capC[capN] = outChan;
        capF[capN] = outFirst; capL[capN] = outLast;
        capN++;
      end
    end
    pClk = sensClk;
    pRst = sensRst;
  end

  function automatic logic [2*SW-1:0] mk(input int v);
    return {SW'(v + 'h80), SW'(v)};
  endfunction

  task automatic chkEq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion earlier", cyc);
      summary();
      $finish;
    end
  end

  task automatic doReset(input logic [1:0] m, input int h, input int ig, input int pr);
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; cfgMode = m;
    cfgHalf = DW'(h); cfgInteg = CW'(ig); cfgPeriod = CW'(pr);
    trigA = 0; trigB = 0; eosA = 0; eosB = 0; adcData = '0; outReady = 1'b1;
    capN = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitRise();
    int r = riseCnt;
    while (riseCnt == r) @(negedge clk);
  endtask

  task automatic waitFall();
    int f = fallCnt;
    while (fallCnt == f) @(negedge clk);
  endtask

  task automatic pulseTrig(input logic a, input logic b, input int v);
    @(negedge clk);
    trigA = a; trigB = b; adcData = mk(v);
    repeat (2) @(negedge clk);
    trigA = 0; trigB = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseEos(input logic a, input logic b);
    @(negedge clk);
    eosA = a; eosB = b;
    repeat (2) @(negedge clk);
    eosA = 0; eosB = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic chkStream(input string req, input int n, input int v0);
    chkEq(req, "sample count", capN, n);
    for (int i = 0; i < n && i < capN; i++) begin
      chkEq(req, "data", capD[i], mk(v0 + i));
      chkEq(req, "channel", capC[i], i + 1);
      chkEq(req, "first marker", capF[i], (i == 0));
      chkEq(req, "last marker", capL[i], (i == n - 1));
    end
  endtask

  task automatic t_reset();
    doReset(2'd0, 3, 4, 10);
    chkEq("R1", "sensRst after reset", sensRst, 0);
    chkEq("R9", "outValid after reset", outValid, 0);
    chkEq("R10", "countErr after reset", countErr, 0);
    chkEq("R9", "overrun after reset", overrun, 0);
    repeat (30) @(negedge clk);
    chkEq("R1", "clock period half=3", clkPer, 6);
    chkEq("R11", "no rise while disabled", riseCnt, 0);
    doReset(2'd0, 0, 4, 10);
    repeat (20) @(negedge clk);
    chkEq("R1", "clock period half=0", clkPer, 2);
  endtask

  task automatic t_single();
    int t0;
    doReset(2'd0, 2, 5, 10);
    enable = 1'b1;
    waitRise(); t0 = riseT;
    waitFall();
    chkEq("R3", "high time", fallT - t0, 5 * 4);
    chkEq("R4", "stretched single", stretched, 1);
    for (int i = 0; i < 4; i++) begin
      pulseTrig(1'b1, 1'b0, 10 + i);
      if (i == 1) pulseTrig(1'b0, 1'b1, 99);  // R7: ignored in single mode
    end
    pulseEos(1'b1, 1'b0);
    chkStream("R6", 4, 10);
    chkEq("R7", "trigB ignored count", capN, 4);
    chkEq("R10", "countErr clean frame", countErr, 0);
    waitRise();
    chkEq("R4", "single period floor", riseT - t0, 33 * 4);
    chkEq("R2", "reset edges off clock rise", r2Bad, 0);
  endtask

  task automatic t_busy();
    int r, te;
    doReset(2'd0, 2, 2, 40);
    enable = 1'b1;
    waitRise();
    waitFall();
    chkEq("R4", "not stretched", stretched, 0);
    for (int i = 0; i < 4; i++) pulseTrig(1'b1, 1'b0, 30 + i);
    r = riseCnt;
    repeat (300) @(negedge clk);
    chkEq("R5", "no rise during readout", riseCnt - r, 0);
    chkEq("R5", "reset low during readout", sensRst, 0);
    @(negedge clk); eosA = 1'b1; te = cyc;
    waitRise();
    eosA = 1'b0;
    chkEq("R5", "prompt rise after end", (riseT - te) <= 10, 1);
    enable = 1'b0;
    waitFall();
    for (int i = 0; i < 4; i++) pulseTrig(1'b1, 1'b0, 30 + i);
    pulseEos(1'b1, 1'b0);
    r = riseCnt;
    repeat (400) @(negedge clk);
    chkEq("R11", "no rise with enable low", riseCnt - r, 0);
    chkEq("R11", "reset held low", sensRst, 0);
    chkEq("R2", "reset edges off clock rise", r2Bad, 0);
  endtask

  task automatic t_cascade();
    int t0;
    doReset(2'd1, 2, 3, 10);
    enable = 1'b1;
    waitRise(); t0 = riseT;
    waitFall();
    chkEq("R4", "stretched cascade", stretched, 1);
    for (int i = 0; i < 4; i++) pulseTrig(1'b1, 1'b0, 20 + i);
    pulseEos(1'b1, 1'b0);
    for (int i = 4; i < 8; i++) pulseTrig(1'b0, 1'b1, 20 + i);
    pulseEos(1'b0, 1'b1);
    chkStream("R8", 8, 20);
    chkEq("R8", "countErr good cascade", countErr, 0);
    waitRise();
    chkEq("R4", "cascade period floor", riseT - t0, 49 * 4);
    doReset(2'd1, 2, 3, 10);
    enable = 1'b1;
    waitFall();
    for (int i = 0; i < 3; i++) pulseTrig(1'b1, 1'b0, 20 + i);
    pulseEos(1'b1, 1'b0);
    chkEq("R8", "early first end of scan", countErr, 1);
  endtask

  task automatic t_parallel();
    int t0;
    doReset(2'd2, 2, 3, 45);
    enable = 1'b1;
    waitRise(); t0 = riseT;
    waitFall();
    chkEq("R4", "parallel not stretched", stretched, 0);
    pulseTrig(1'b1, 1'b1, 40);
    pulseTrig(1'b1, 1'b1, 41);
    @(negedge clk); trigA = 1'b1; adcData = mk(42);
    @(negedge clk); trigB = 1'b1;
    repeat (2) @(negedge clk); trigA = 1'b0;
    @(negedge clk); trigB = 1'b0;
    repeat (2) @(negedge clk);
    pulseTrig(1'b0, 1'b1, 43);
    pulseEos(1'b1, 1'b0);
    chkStream("R7", 4, 40);
    chkEq("R10", "countErr parallel", countErr, 0);
    waitRise();
    chkEq("R4", "parallel programmed period", riseT - t0, 45 * 4);
  endtask

  task automatic t_backpressure();
    logic [2*SW-1:0] held;
    doReset(2'd0, 2, 3, 10);
    outReady = 1'b0;
    enable = 1'b1;
    waitFall();
    pulseTrig(1'b1, 1'b0, 50);
    chkEq("R9", "valid after capture", outValid, 1);
    chkEq("R6", "first channel", outChan, 1);
    held = outData;
    repeat (5) @(negedge clk);
    chkEq("R9", "valid held", outValid, 1);
    chkEq("R9", "data held", outData, held);
    chkEq("R9", "no overrun yet", overrun, 0);
    pulseTrig(1'b1, 1'b0, 51);
    chkEq("R9", "overrun set", overrun, 1);
    chkEq("R9", "newer word kept", outData, mk(51));
    chkEq("R9", "newer channel", outChan, 2);
    #1 outReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chkEq("R9", "valid drops after ready", outValid, 0);
  endtask

  task automatic t_count();
    doReset(2'd0, 2, 3, 10);
    enable = 1'b1;
    waitFall();
    for (int i = 0; i < 5; i++) pulseTrig(1'b1, 1'b0, 60 + i);
    chkEq("R10", "surplus strobe flagged", countErr, 1);
    chkEq("R10", "surplus strobe dropped", capN, 4);
    doReset(2'd0, 2, 3, 10);
    enable = 1'b1;
    waitFall();
    for (int i = 0; i < 3; i++) pulseTrig(1'b1, 1'b0, 60 + i);
    chkEq("R10", "no error before end", countErr, 0);
    pulseEos(1'b1, 1'b0);
    chkEq("R10", "short readout flagged", countErr, 1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_busy();
    t_cascade();
    t_parallel();
    t_backpressure();
    t_count();
    summary();
    $finish;
  end

endmodule